// File: doc/BRIEF.md
# Flash Write-Protect and High-Voltage Enable Gate

This block guards the high-voltage enable of an on-chip flash array. Software drives it through a small register interface: a control register that selects byte program, page erase or mass erase and requests high voltage, a protect register that marks one contiguous protected region reaching up to address 0xFFFF, and a status register of sticky flags. The flash array's own write strobe lets the block capture the target address of the operation. Before raising the enable, the block checks the captured address against the protected region, the mass-erase lockout, the lock on the protect register itself, and a required arming step.

A board-level test-voltage input lifts every protection check. The high-voltage enable stays on until software clears it or a cycle limit runs out. When a permitted erase covers the page that holds the protect register, the register returns to its open value.

Top module: `flash_guard`

## Requirements
- R1: After reset the protect register (select 1) reads 0xFF, the control register (select 0) and the status register (select 2) read 0, and `hv_en` is low.
- R2: For a protect value P other than 0x00 and 0xFF, the protected region starts at 0xFF00 - P*64 and runs to 0xFFFF. P=0xFF protects nothing and P=0x00 protects everything. A byte program checks its own address. A page erase (64-byte pages) checks the last byte of its page.
- R3: A high-voltage request (control bit 3) for a protected target leaves `hv_en` low and sets the sticky violation flag (status bit 0). Writing 1 to that bit clears it.
- R4: A mass erase (control bits 1 and 2 both set) is refused whenever P is not 0xFF.
- R5: While P is neither 0xFF nor 0xFE, a write to the protect register is ignored and sets the violation flag. In the same state, a page erase of the page that holds the protect register is refused.
- R6: While `hv_bypass` is high, all protection checks of R2, R4 and R5 are lifted.
- R7: A high-voltage request is ignored, with no flag set, unless the protect register was read after the program or erase bit was written. The request must repeat the current operation bits (bit 0 program, bit 1 erase, bit 2 mass).
- R8: A granted mass erase, or a granted page erase of the page holding the protect register (default address 0xFF7E), sets P to 0xFF.
- R9: Writing program and erase together sets neither bit and sets the sequence-error flag (status bit 2).
- R10: A granted `hv_en` stays high for at most MAX_HV cycles. At the limit it drops and sets the timeout flag (status bit 1).
- R11: Any control write that is not a valid high-voltage request drops `hv_en`. Control bit 3 reads back as `hv_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_sel | input | 2 | Register select: 0 control, 1 protect, 2 status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| arr_we | input | 1 | Flash array write strobe; captures the target address |
| arr_addr | input | 16 | Target address of the program or erase |
| hv_bypass | input | 1 | Test-voltage present; lifts protection |
| hv_en | output | 1 | High-voltage enable to the flash array |

## Verification
The bench builds the block with MAX_HV=12 in place of the long default limit, so the timeout and the exact on-time of the enable can be observed within a short run. Every other parameter keeps its default: a 64-byte page, a start top of 0xFF00 and the protect register at 0xFF7E. With these defaults, the vector addresses sit one byte on either side of the computed region starts for several protect values, and the register's own page can be erased under bypass.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

  // Region start: TOP minus (value << SHIFT), clamped at zero.
  function automatic logic [15:0] prot_start(input logic [7:0] p,
                                             input int unsigned top,
                                             input int unsigned sh);
    int unsigned off;
    off = int'(p) << sh;
    return (off > top) ? 16'h0000 : 16'(top - off);
  endfunction

  // Address falls in the protected region for value p.
  function automatic logic addr_locked(input logic [7:0] p,
                                       input logic [15:0] a,
                                       input int unsigned top,
                                       input int unsigned sh);
    if (p == 8'hFF) return 1'b0;
    if (p == 8'h00) return 1'b1;
    return a >= prot_start(p, top, sh);
  endfunction

endpackage

// File: rtl/flash_guard_policy.sv
module flash_guard_policy
  import flash_guard_pkg::*;
#(
  parameter int unsigned START_TOP  = 16'hFF00,
  parameter int unsigned STEP_SHIFT = 6,
  parameter int unsigned PAGE_BYTES = 64,
  parameter int unsigned REG_ADDR   = 16'hFF7E
) (
  input  logic [7:0]  prot,
  input  logic        op_pgm,
  input  logic        op_erase,
  input  logic        op_mass,
  input  logic [15:0] addr,
  input  logic        bypass,
  output logic        allow,
  output logic        reset_prot
);
  localparam logic [15:0] PAGE_MASK = 16'(PAGE_BYTES - 1);
  localparam logic [15:0] REG_PAGE  = 16'(REG_ADDR) & ~PAGE_MASK;

  logic [15:0] chk_addr;
  logic        in_region, hits_reg, reg_locked, deny;

  always_comb begin
    chk_addr   = op_erase ? (addr | PAGE_MASK) : addr;
    in_region  = addr_locked(prot, chk_addr, START_TOP, STEP_SHIFT);
    hits_reg   = op_erase && ((addr & ~PAGE_MASK) == REG_PAGE);
    reg_locked = (prot != 8'hFF) && (prot != 8'hFE);
    if (op_mass)
      deny = (prot != 8'hFF);
    else
      deny = in_region || (hits_reg && reg_locked);
    allow      = (op_pgm || op_erase) && (bypass || !deny);
    reset_prot = op_erase && (op_mass || hits_reg);
  end

endmodule

// File: rtl/flash_guard_hvtimer.sv
module flash_guard_hvtimer #(
  parameter int unsigned MAX_HV = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic stop,
  output logic hv_on,
  output logic expire
);
  localparam int unsigned CW = $clog2(MAX_HV + 1);
  localparam logic [CW-1:0] LAST = CW'(MAX_HV - 1);

  logic [CW-1:0] cnt_q;

  assign expire = hv_on && !start && !stop && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hv_on <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      hv_on <= 1'b1;
      cnt_q <= '0;
    end else if (stop || expire) begin
      hv_on <= 1'b0;
      cnt_q <= '0;
    end else if (hv_on) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_HV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    hv_on |-> (cnt_q <= LAST)); // R10
  AST_EXPIRE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !hv_on); // R10

endmodule

// File: rtl/flash_guard.sv
module flash_guard #(
  parameter int unsigned START_TOP  = 16'hFF00,
  parameter int unsigned STEP_SHIFT = 6,
  parameter int unsigned PAGE_BYTES = 64,
  parameter int unsigned REG_ADDR   = 16'hFF7E,
  parameter int unsigned MAX_HV     = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [1:0]  bus_sel,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic        arr_we,
  input  logic [15:0] arr_addr,
  input  logic        hv_bypass,
  output logic        hv_en
);
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_PROT = 2'd1;
  localparam logic [1:0] SEL_STAT = 2'd2;

  logic [7:0]  prot_q;
  logic [15:0] tgt_q;
  logic        pgm_q, erase_q, mass_q, armed_q;
  logic        viol_q, tmo_q, seq_q;

  logic wr_ctrl, wr_prot, wr_stat, rd_prot;
  logic both_ops, hv_req, grant, deny_evt, stop_evt;
  logic prot_ok, prot_bad;
  logic allow, reset_prot, expire;

  assign wr_ctrl = bus_wr && (bus_sel == SEL_CTRL);
  assign wr_prot = bus_wr && (bus_sel == SEL_PROT);
  assign wr_stat = bus_wr && (bus_sel == SEL_STAT);
  assign rd_prot = bus_rd && (bus_sel == SEL_PROT);

  assign both_ops = bus_wdata[0] && bus_wdata[1];
  assign hv_req   = wr_ctrl && bus_wdata[3] && !both_ops
                 && (bus_wdata[0] || bus_wdata[1])
                 && (bus_wdata[0] == pgm_q) && (bus_wdata[1] == erase_q)
                 && (bus_wdata[2] == mass_q);
  assign grant    = hv_req && armed_q && allow;
  assign deny_evt = hv_req && armed_q && !allow;
  assign stop_evt = wr_ctrl && !grant;

  assign prot_ok  = wr_prot && (hv_bypass || prot_q == 8'hFF || prot_q == 8'hFE);
  assign prot_bad = wr_prot && !prot_ok;

  flash_guard_policy #(
    .START_TOP(START_TOP), .STEP_SHIFT(STEP_SHIFT),
    .PAGE_BYTES(PAGE_BYTES), .REG_ADDR(REG_ADDR)
  ) u_policy (
    .prot(prot_q), .op_pgm(pgm_q), .op_erase(erase_q), .op_mass(mass_q),
    .addr(tgt_q), .bypass(hv_bypass), .allow(allow), .reset_prot(reset_prot)
  );

  flash_guard_hvtimer #(.MAX_HV(MAX_HV)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(grant), .stop(stop_evt),
    .hv_on(hv_en), .expire(expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q  <= 8'hFF;
      tgt_q   <= '0;
      pgm_q   <= 1'b0;
      erase_q <= 1'b0;
      mass_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (arr_we) tgt_q <= arr_addr;
      if (grant && reset_prot) prot_q <= 8'hFF;
      else if (prot_ok)        prot_q <= bus_wdata;
      if (wr_ctrl && !hv_req) begin
        armed_q <= 1'b0;
        if (both_ops) begin
          pgm_q   <= 1'b0;
          erase_q <= 1'b0;
          mass_q  <= 1'b0;
        end else begin
          pgm_q   <= bus_wdata[0];
          erase_q <= bus_wdata[1];
          mass_q  <= bus_wdata[2] && bus_wdata[1];
        end
      end else if (rd_prot && (pgm_q || erase_q)) begin
        armed_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_q <= 1'b0;
      tmo_q  <= 1'b0;
      seq_q  <= 1'b0;
    end else begin
      viol_q <= (deny_evt || prot_bad)       || (viol_q && !(wr_stat && bus_wdata[0]));
      tmo_q  <= expire                       || (tmo_q  && !(wr_stat && bus_wdata[1]));
      seq_q  <= (wr_ctrl && both_ops)        || (seq_q  && !(wr_stat && bus_wdata[2]));
    end
  end

  always_comb begin
    case (bus_sel)
      SEL_CTRL: bus_rdata = {4'b0, hv_en, mass_q, erase_q, pgm_q};
      SEL_PROT: bus_rdata = prot_q;
      SEL_STAT: bus_rdata = {5'b0, seq_q, tmo_q, viol_q};
      default:  bus_rdata = 8'h00;
    endcase
  end

  AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
    !(pgm_q && erase_q)); // R9
  AST_HV_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hv_en) |-> $past(armed_q)); // R7
  AST_HV_POLICY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hv_en) |-> $past(allow)); // R3
  AST_MASS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hv_en) && mass_q) |-> ($past(prot_q) == 8'hFF || $past(hv_bypass))); // R4
  AST_HV_HAS_OP: assert property (@(posedge clk) disable iff (!rst_n)
    hv_en |-> (pgm_q || erase_q)); // R11

endmodule

// File: tb/flash_guard_tb.sv
module flash_guard_tb;
  localparam int unsigned MAX_HV = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_sel = 2'd0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic        arr_we = 1'b0;
  logic [15:0] arr_addr = 16'h0000;
  logic        hv_bypass = 1'b0;
  logic        hv_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  flash_guard #(.MAX_HV(MAX_HV)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .arr_we(arr_we), .arr_addr(arr_addr), .hv_bypass(hv_bypass), .hv_en(hv_en)
  );

  // {protect value, op (0 program, 1 page erase, 2 mass), address, bypass, expected hv}
  localparam logic [27:0] VEC [12] = '{
    {8'hFF, 2'd0, 16'h8000, 1'b0, 1'b1},
    {8'h00, 2'd0, 16'h8000, 1'b0, 1'b0},
    {8'h01, 2'd0, 16'hFEBF, 1'b0, 1'b1},
    {8'h01, 2'd0, 16'hFEC0, 1'b0, 1'b0},
    {8'h10, 2'd1, 16'hFAC5, 1'b0, 1'b1},
    {8'h10, 2'd1, 16'hFB05, 1'b0, 1'b0},
    {8'hFF, 2'd2, 16'h8000, 1'b0, 1'b1},
    {8'hFE, 2'd2, 16'h8000, 1'b0, 1'b0},
    {8'h00, 2'd0, 16'hFFFF, 1'b1, 1'b1},
    {8'h80, 2'd2, 16'h8000, 1'b1, 1'b1},
    {8'hFE, 2'd0, 16'hBF7F, 1'b0, 1'b1},
    {8'hFE, 2'd0, 16'hBF80, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    bus_sel = sel; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [7:0] d);
    @(negedge clk);
    bus_sel = sel; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic set_prot(input logic [7:0] p);
    hv_bypass = 1'b1;
    wr(2'd1, p);
    hv_bypass = 1'b0;
  endtask

  function automatic logic [7:0] op_bits(input logic [1:0] op);
    return (op == 2'd0) ? 8'h01 : (op == 2'd1) ? 8'h02 : 8'h06;
  endfunction

  task automatic run_op(input logic [1:0] op, input logic [15:0] a,
                        input logic byp, input bit arm);
    logic [7:0] dummy;
    hv_bypass = byp;
    wr(2'd0, op_bits(op));
    if (arm) rd(2'd1, dummy);
    @(negedge clk);
    arr_addr = a; arr_we = 1'b1;
    @(negedge clk);
    arr_we = 1'b0;
    wr(2'd0, op_bits(op) | 8'h08);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    if (!done) $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] r;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, r); check("R1 ctrl", 16'(r), 16'h00);
    rd(2'd1, r); check("R1 prot", 16'(r), 16'hFF);
    rd(2'd2, r); check("R1 stat", 16'(r), 16'h00);
    check("R1 hv_en", 16'(hv_en), 16'h0);

    // R2 R3 R4 R6 R11 vector table
    foreach (VEC[i]) begin
      logic [27:0] v;
      v = VEC[i];
      set_prot(v[27:20]);
      run_op(v[19:18], v[17:2], v[1], 1'b1);
      check($sformatf("R2/R4/R6 vec%0d hv", i), 16'(hv_en), 16'(v[0]));
      rd(2'd2, r);
      check($sformatf("R3 vec%0d violation", i), 16'(r[0]), 16'(!v[0]));
      wr(2'd0, 8'h00);
      check($sformatf("R11 vec%0d hv drop", i), 16'(hv_en), 16'h0);
      wr(2'd2, 8'h07);
      rd(2'd2, r);
      check($sformatf("R3 vec%0d w1c", i), 16'(r), 16'h00);
    end

    // R7 request without arming read is ignored
    set_prot(8'hFF);
    run_op(2'd0, 16'h8000, 1'b0, 1'b0);
    check("R7 hv unarmed", 16'(hv_en), 16'h0);
    rd(2'd2, r); check("R7 no flag", 16'(r), 16'h00);

    // R11 read back of hv bit and drop
    run_op(2'd0, 16'h8000, 1'b0, 1'b1);
    rd(2'd0, r); check("R11 ctrl hv bit", 16'(r), 16'h09);
    wr(2'd0, 8'h01);
    check("R11 hv drop", 16'(hv_en), 16'h0);
    wr(2'd0, 8'h00);

    // R5 unlocked value accepts write, locked value refuses
    set_prot(8'hFE);
    wr(2'd1, 8'h55);
    rd(2'd1, r); check("R5 write while FE", 16'(r), 16'h55);
    wr(2'd1, 8'hFF);
    rd(2'd1, r); check("R5 locked write ignored", 16'(r), 16'h55);
    rd(2'd2, r); check("R5 locked write flag", 16'(r), 16'h01);
    wr(2'd2, 8'h01);

    // R8 erase of register page under bypass reopens protection
    set_prot(8'h00);
    run_op(2'd1, 16'hFF7E, 1'b1, 1'b1);
    check("R8 hv granted", 16'(hv_en), 16'h1);
    hv_bypass = 1'b0;
    rd(2'd1, r); check("R8 prot reset", 16'(r), 16'hFF);
    wr(2'd0, 8'h00);

    // R9 both op bits
    wr(2'd0, 8'h03);
    rd(2'd0, r); check("R9 ctrl", 16'(r), 16'h00);
    rd(2'd2, r); check("R9 seq flag", 16'(r), 16'h04);
    wr(2'd2, 8'h04);

    // R10 timeout after MAX_HV cycles
    run_op(2'd0, 16'h8000, 1'b0, 1'b1);
    n = 0;
    while (hv_en && n < 40) begin
      n++;
      @(negedge clk);
    end
    check("R10 on-time", 16'(n), 16'(MAX_HV));
    rd(2'd2, r); check("R10 timeout flag", 16'(r), 16'h02);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule